// File: doc/BRIEF.md
# Hardwired Instruction Sequencer for a 16-bit Accumulator Core

This block is the hardwired control unit of a small accumulator machine, together with the registers it steers. A four-bit step counter is decoded into one-hot phase signals. The three opcode bits of the instruction word are decoded into eight one-hot lines, and a flag holds the addressing-mode bit. From these signals and a few datapath status bits, combinational logic produces the following controls for every cycle:

- the source select for a shared internal bus;
- the load, increment and clear enables for each register;
- the memory write strobe.

Each instruction is fetched in two phases and decoded in a third. The fourth phase either resolves an indirect address or executes a register-form instruction. Memory-form instructions then run their own short sequence, and every sequence ends by clearing the step counter. Memory is external and asynchronous-read: the address always comes from the address register, and writes take effect on the clock edge while the write strobe is high.

Top module: `hw_seq_ctrl`

## Requirements
- R1: While rst_n is low, phase, pc_q, ac_q, e_q and halted are all zero, and the core restarts fetching from address 0 after release.
- R2: Fetch and decode work as follows. The phase advances by one per clock. In phase 0 the address register takes the PC. In phase 1 the memory word is loaded into the instruction register and the PC increments. In phase 2 bit 15 is captured as the mode flag and bits 11..0 become the address. Opcode field 14..12 selects 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 register/IO form.
- R3: For opcodes 0..6 with bit 15 set, phase 3 replaces the address with bits 11..0 of the addressed word. The instruction takes no more cycles than its direct form.
- R4: AND, ADD and LDA read the operand in phase 4 and update the accumulator in phase 5, taking 6 cycles. ADD places its carry-out in E.
- R5: STA writes the accumulator to the addressed word, and BUN jumps to the address. Each takes 5 cycles, and memory is written only in phase 4 or 6.
- R6: BSA stores the PC at the address and continues at address+1, taking 6 cycles.
- R7: ISZ increments the addressed word and skips the next instruction when the result is zero, taking 7 cycles.
- R8: Opcode 7 with bit 15 clear finishes in phase 3 (4 cycles) and carries one set bit in 11..0 that selects the operation:
  - bit 11 clears AC;
  - bit 10 clears E;
  - bit 9 complements AC;
  - bit 8 complements E;
  - bit 7 rotates {AC,E} right;
  - bit 6 rotates {AC,E} left;
  - bit 5 increments AC.
- R9: In the same form, bit 4 skips if AC bit 15 is 0, bit 3 skips if AC bit 15 is 1, bit 2 skips if AC is zero, and bit 1 skips if E is 0.
- R10: In the same form, bit 0 halts. After halting, halted is 1 and phase and pc_q stay frozen (phase 0) until reset.
- R11: Opcode 7 with bit 15 set finishes in phase 3 without changing AC, E or memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Memory word address (address register) |
| mem_rdata | input | DATA_W | Asynchronous read data of the addressed word |
| mem_wdata | output | DATA_W | Write data (internal bus value) |
| mem_we | output | 1 | Write strobe, applied at the rising edge |
| ac_q | output | DATA_W | Accumulator |
| e_q | output | 1 | Carry/extension flag |
| pc_q | output | ADDR_W | Program counter |
| halted | output | 1 | Core has executed a halt |
| phase | output | SC_W | Current step counter value |

## Verification
Each result is due at a known cycle. The operand fetch happens in phase 4, an accumulator update lands on the edge that ends phase 5, memory writes land on the edge that ends phase 4 or 6, and the halt flag rises on the edge that ends phase 3 of the halt instruction. Every test program therefore has a fixed length: 6 cycles for the loading instruction, plus 4, 5, 6 or 7 cycles for the instruction under test, plus 4 cycles for the halt. The bench counts rising edges from reset release until it samples halted high at a falling edge, and compares that count with the expected total. Register and memory contents are compared only after halting, and in the fetch test the phase and address are sampled at the falling edge after each counted rising edge.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

   // Bus source codes: the numeric values are the select encoding of the shared bus
   typedef enum logic [2:0] {
      BUS_NONE = 3'd0,
      BUS_AR   = 3'd1,
      BUS_PC   = 3'd2,
      BUS_DR   = 3'd3,
      BUS_AC   = 3'd4,
      BUS_IR   = 3'd5,
      BUS_MEM  = 3'd7
   } bus_sel_e;

   typedef enum logic [3:0] {
      ALU_HOLD,
      ALU_AND,
      ALU_ADD,
      ALU_LOAD,
      ALU_CLA,
      ALU_CLE,
      ALU_CMA,
      ALU_CME,
      ALU_CIR,
      ALU_CIL,
      ALU_INC
   } alu_op_e;

   typedef struct packed {
      bus_sel_e bus_sel;
      logic     ar_ld;
      logic     ar_inr;
      logic     pc_ld;
      logic     pc_inr;
      logic     dr_ld;
      logic     dr_inr;
      logic     ir_ld;
      logic     i_ld;
      logic     mem_we;
      logic     sc_clr;
      logic     halt_set;
      alu_op_e  alu_op;
   } ctrl_t;

   // Opcode line indices
   localparam int OP_AND = 0;
   localparam int OP_ADD = 1;
   localparam int OP_LDA = 2;
   localparam int OP_STA = 3;
   localparam int OP_BUN = 4;
   localparam int OP_BSA = 5;
   localparam int OP_ISZ = 6;
   localparam int OP_REG = 7;

   // Register-form operation bits in the address field
   localparam int RB_CLA = 11;
   localparam int RB_CLE = 10;
   localparam int RB_CMA = 9;
   localparam int RB_CME = 8;
   localparam int RB_CIR = 7;
   localparam int RB_CIL = 6;
   localparam int RB_INC = 5;
   localparam int RB_SPA = 4;
   localparam int RB_SNA = 3;
   localparam int RB_SZA = 2;
   localparam int RB_SZE = 1;
   localparam int RB_HLT = 0;

   // Highest phase any sequence reaches, plus one
   localparam int PHASES_USED = 7;

endpackage

// File: rtl/seqc_timing.sv
module seqc_timing #(
   parameter int SC_W   = 4,
   parameter int NUM_PH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sc_clr,
   input  logic              halt_set,
   output logic [SC_W-1:0]   sc,
   output logic              halted,
   output logic [NUM_PH-1:0] t
);

   localparam int PH_MAX = 1 << SC_W;

   if (NUM_PH > PH_MAX) begin : g_bad_width
      $error("seqc_timing: SC_W too narrow for NUM_PH");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc     <= '0;
         halted <= 1'b0;
      end else begin
         if (halt_set) halted <= 1'b1;
         if (!halted) begin
            if (sc_clr) sc <= '0;
            else        sc <= sc + 1'b1;
         end
      end
   end

   for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
      assign t[k] = (sc == SC_W'(k));
   end

endmodule

// File: rtl/seqc_decode.sv
module seqc_decode #(
   parameter int DATA_W = 16,
   parameter int OP_W   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     ir,
   input  logic                  i_ld,
   output logic [(1<<OP_W)-1:0]  d,
   output logic                  i_q
);

   localparam int OP_HI = DATA_W - 2;
   localparam int N_OPS = 1 << OP_W;

   logic [OP_W-1:0] opf;
   assign opf = ir[OP_HI -: OP_W];

   for (genvar k = 0; k < N_OPS; k++) begin : g_op
      assign d[k] = (opf == OP_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    i_q <= 1'b0;
      else if (i_ld) i_q <= ir[DATA_W-1];
   end

endmodule

// File: rtl/seqc_ctrl.sv
module seqc_ctrl
   import seqc_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NUM_PH = 7
) (
   input  logic [NUM_PH-1:0] t,
   input  logic [7:0]        d,
   input  logic              i_q,
   input  logic [ADDR_W-1:0] ir_addr,
   input  logic              dr_zero,
   input  logic              ac_zero,
   input  logic              ac_neg,
   input  logic              e_q,
   output ctrl_t             ctl
);

   always_comb begin
      ctl = '0;
      if (t[0]) begin
         ctl.bus_sel = BUS_PC;
         ctl.ar_ld   = 1'b1;
      end
      if (t[1]) begin
         ctl.bus_sel = BUS_MEM;
         ctl.ir_ld   = 1'b1;
         ctl.pc_inr  = 1'b1;
      end
      if (t[2]) begin
         ctl.bus_sel = BUS_IR;
         ctl.ar_ld   = 1'b1;
         ctl.i_ld    = 1'b1;
      end
      if (t[3]) begin
         if (!d[OP_REG]) begin
            if (i_q) begin
               ctl.bus_sel = BUS_MEM;
               ctl.ar_ld   = 1'b1;
            end
         end else begin
            ctl.sc_clr = 1'b1;
            if (!i_q) begin
               if      (ir_addr[RB_CLA]) ctl.alu_op   = ALU_CLA;
               else if (ir_addr[RB_CLE]) ctl.alu_op   = ALU_CLE;
               else if (ir_addr[RB_CMA]) ctl.alu_op   = ALU_CMA;
               else if (ir_addr[RB_CME]) ctl.alu_op   = ALU_CME;
               else if (ir_addr[RB_CIR]) ctl.alu_op   = ALU_CIR;
               else if (ir_addr[RB_CIL]) ctl.alu_op   = ALU_CIL;
               else if (ir_addr[RB_INC]) ctl.alu_op   = ALU_INC;
               else if (ir_addr[RB_SPA]) ctl.pc_inr   = !ac_neg;
               else if (ir_addr[RB_SNA]) ctl.pc_inr   = ac_neg;
               else if (ir_addr[RB_SZA]) ctl.pc_inr   = ac_zero;
               else if (ir_addr[RB_SZE]) ctl.pc_inr   = !e_q;
               else if (ir_addr[RB_HLT]) ctl.halt_set = 1'b1;
            end
         end
      end
      if (t[4]) begin
         if (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]) begin
            ctl.bus_sel = BUS_MEM;
            ctl.dr_ld   = 1'b1;
         end else if (d[OP_STA]) begin
            ctl.bus_sel = BUS_AC;
            ctl.mem_we  = 1'b1;
            ctl.sc_clr  = 1'b1;
         end else if (d[OP_BUN]) begin
            ctl.bus_sel = BUS_AR;
            ctl.pc_ld   = 1'b1;
            ctl.sc_clr  = 1'b1;
         end else if (d[OP_BSA]) begin
            ctl.bus_sel = BUS_PC;
            ctl.mem_we  = 1'b1;
            ctl.ar_inr  = 1'b1;
         end
      end
      if (t[5]) begin
         if (d[OP_AND]) begin
            ctl.alu_op = ALU_AND;
            ctl.sc_clr = 1'b1;
         end else if (d[OP_ADD]) begin
            ctl.alu_op = ALU_ADD;
            ctl.sc_clr = 1'b1;
         end else if (d[OP_LDA]) begin
            ctl.alu_op = ALU_LOAD;
            ctl.sc_clr = 1'b1;
         end else if (d[OP_BSA]) begin
            ctl.bus_sel = BUS_AR;
            ctl.pc_ld   = 1'b1;
            ctl.sc_clr  = 1'b1;
         end else if (d[OP_ISZ]) begin
            ctl.dr_inr = 1'b1;
         end
      end
      if (t[6] && d[OP_ISZ]) begin
         ctl.bus_sel = BUS_DR;
         ctl.mem_we  = 1'b1;
         ctl.pc_inr  = dr_zero;
         ctl.sc_clr  = 1'b1;
      end
   end

endmodule

// File: rtl/seqc_datapath.sv
module seqc_datapath
   import seqc_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter bit CARRY_TO_E = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_t             ctl,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] bus,
   output logic [ADDR_W-1:0] ar,
   output logic [ADDR_W-1:0] pc,
   output logic [DATA_W-1:0] ir,
   output logic [DATA_W-1:0] ac,
   output logic              e,
   output logic              dr_zero,
   output logic              ac_zero,
   output logic              ac_neg
);

   logic [DATA_W-1:0] dr;
   logic [DATA_W:0]   add_full;
   logic              add_e;

   always_comb begin
      unique case (ctl.bus_sel)
         BUS_AR:  bus = DATA_W'(ar);
         BUS_PC:  bus = DATA_W'(pc);
         BUS_DR:  bus = dr;
         BUS_AC:  bus = ac;
         BUS_IR:  bus = ir;
         BUS_MEM: bus = mem_rdata;
         default: bus = '0;
      endcase
   end

   assign add_full = {1'b0, ac} + {1'b0, dr};

   if (CARRY_TO_E) begin : g_carry_e
      assign add_e = add_full[DATA_W];
   end else begin : g_keep_e
      assign add_e = e;
   end

   assign dr_zero = (dr == '0);
   assign ac_zero = (ac == '0);
   assign ac_neg  = ac[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar <= '0;
         pc <= '0;
         dr <= '0;
         ir <= '0;
      end else begin
         if (ctl.ar_ld)       ar <= bus[ADDR_W-1:0];
         else if (ctl.ar_inr) ar <= ar + 1'b1;
         if (ctl.pc_ld)       pc <= bus[ADDR_W-1:0];
         else if (ctl.pc_inr) pc <= pc + 1'b1;
         if (ctl.dr_ld)       dr <= bus;
         else if (ctl.dr_inr) dr <= dr + 1'b1;
         if (ctl.ir_ld)       ir <= bus;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac <= '0;
         e  <= 1'b0;
      end else begin
         case (ctl.alu_op)
            ALU_AND:  ac <= ac & dr;
            ALU_ADD: begin
               ac <= add_full[DATA_W-1:0];
               e  <= add_e;
            end
            ALU_LOAD: ac <= dr;
            ALU_CLA:  ac <= '0;
            ALU_CLE:  e  <= 1'b0;
            ALU_CMA:  ac <= ~ac;
            ALU_CME:  e  <= ~e;
            ALU_CIR: begin
               ac <= {e, ac[DATA_W-1:1]};
               e  <= ac[0];
            end
            ALU_CIL: begin
               ac <= {ac[DATA_W-2:0], e};
               e  <= ac[DATA_W-1];
            end
            ALU_INC:  ac <= ac + 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
   import seqc_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter int OP_W       = 3,
   parameter int SC_W       = 4,
   parameter bit CARRY_TO_E = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic [DATA_W-1:0] ac_q,
   output logic              e_q,
   output logic [ADDR_W-1:0] pc_q,
   output logic              halted,
   output logic [SC_W-1:0]   phase
);

   localparam int NUM_PH = PHASES_USED;
   localparam int N_OPS  = 1 << OP_W;

   if (DATA_W != ADDR_W + OP_W + 1) begin : g_bad_fmt
      $error("hw_seq_ctrl: DATA_W must equal ADDR_W + OP_W + 1");
   end
   if (OP_W != 3) begin : g_bad_op
      $error("hw_seq_ctrl: sequencer decodes exactly eight opcodes");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("hw_seq_ctrl: register-form bits need ADDR_W >= 12");
   end

   ctrl_t               ctl;
   logic [NUM_PH-1:0]   t;
   logic [N_OPS-1:0]    d;
   logic                i_q;
   logic [DATA_W-1:0]   ir;
   logic [DATA_W-1:0]   bus;
   logic [ADDR_W-1:0]   ar;
   logic                dr_zero, ac_zero, ac_neg;

   seqc_timing #(.SC_W(SC_W), .NUM_PH(NUM_PH)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .sc_clr   (ctl.sc_clr),
      .halt_set (ctl.halt_set),
      .sc       (phase),
      .halted   (halted),
      .t        (t)
   );

   seqc_decode #(.DATA_W(DATA_W), .OP_W(OP_W)) u_decode (
      .clk   (clk),
      .rst_n (rst_n),
      .ir    (ir),
      .i_ld  (ctl.i_ld),
      .d     (d),
      .i_q   (i_q)
   );

   seqc_ctrl #(.ADDR_W(ADDR_W), .NUM_PH(NUM_PH)) u_ctrl (
      .t       (t),
      .d       (d),
      .i_q     (i_q),
      .ir_addr (ir[ADDR_W-1:0]),
      .dr_zero (dr_zero),
      .ac_zero (ac_zero),
      .ac_neg  (ac_neg),
      .e_q     (e_q),
      .ctl     (ctl)
   );

   seqc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CARRY_TO_E(CARRY_TO_E)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl       (ctl),
      .mem_rdata (mem_rdata),
      .bus       (bus),
      .ar        (ar),
      .pc        (pc_q),
      .ir        (ir),
      .ac        (ac_q),
      .e         (e_q),
      .dr_zero   (dr_zero),
      .ac_zero   (ac_zero),
      .ac_neg    (ac_neg)
   );

   assign mem_addr  = ar;
   assign mem_wdata = bus;
   assign mem_we    = ctl.mem_we;

endmodule

// File: rtl/seqc_chk.sv
module seqc_chk #(
   parameter int SC_W   = 4,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SC_W-1:0]   phase,
   input logic              halted,
   input logic [ADDR_W-1:0] pc_q,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we
);

   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !halted |=> (phase == '0) || (phase == SC_W'($past(phase) + 1'b1))); // R2

   AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == SC_W'(1)) |-> (mem_addr == pc_q)); // R2

   AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == SC_W'(1)) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1))); // R2

   AST_PHASE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= SC_W'(6)); // R4

   AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (phase == SC_W'(4)) || (phase == SC_W'(6))); // R5

   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(phase) && $stable(pc_q) && (phase == '0)); // R10

endmodule

bind hw_seq_ctrl seqc_chk #(.SC_W(SC_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase    (phase),
   .halted   (halted),
   .pc_q     (pc_q),
   .mem_addr (mem_addr),
   .mem_we   (mem_we)
);

// File: tb/hw_seq_ctrl_tb.sv
`timescale 1ns/1ps
module hw_seq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic [15:0] mem_rdata, mem_wdata;
   logic        mem_we;
   logic [15:0] ac_q;
   logic        e_q;
   logic [11:0] pc_q;
   logic        halted;
   logic [3:0]  phase;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   logic [15:0] mem [256];

   always #2.5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

   hw_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .ac_q(ac_q), .e_q(e_q),
      .pc_q(pc_q), .halted(halted), .phase(phase)
   );

   // Program: 0: LDA 0x10 ; 1: instruction under test ; every other word halts
   typedef struct packed {
      logic [7:0]  req;
      logic [15:0] a_val;
      logic [15:0] instr;
      logic [15:0] b_val;
      logic [15:0] exp_ac;
      logic        exp_e;
      logic [15:0] exp_m20;
      logic [11:0] exp_pc;
      logic [7:0]  exp_cyc;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{8'd4,  16'hF0F0, 16'h0020, 16'h3C3C, 16'h3030, 1'b0, 16'h3C3C, 12'h003, 8'd16}, // R4 AND
      '{8'd4,  16'h1234, 16'h1020, 16'h1111, 16'h2345, 1'b0, 16'h1111, 12'h003, 8'd16}, // R4 ADD
      '{8'd4,  16'hFFFF, 16'h1020, 16'h0002, 16'h0001, 1'b1, 16'h0002, 12'h003, 8'd16}, // R4 carry
      '{8'd3,  16'h0000, 16'hA030, 16'h5A5A, 16'h5A5A, 1'b0, 16'h5A5A, 12'h003, 8'd16}, // R3 LDA ind
      '{8'd3,  16'h0001, 16'h9030, 16'h0002, 16'h0003, 1'b0, 16'h0002, 12'h003, 8'd16}, // R3 ADD ind
      '{8'd5,  16'hBEEF, 16'h3020, 16'h0000, 16'hBEEF, 1'b0, 16'hBEEF, 12'h003, 8'd15}, // R5 STA
      '{8'd5,  16'h0042, 16'h4005, 16'h0000, 16'h0042, 1'b0, 16'h0000, 12'h006, 8'd15}, // R5 BUN
      '{8'd6,  16'h0042, 16'h5020, 16'h0000, 16'h0042, 1'b0, 16'h0002, 12'h022, 8'd16}, // R6 BSA
      '{8'd7,  16'h0000, 16'h6020, 16'h0005, 16'h0000, 1'b0, 16'h0006, 12'h003, 8'd17}, // R7 no skip
      '{8'd7,  16'h0000, 16'h6020, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 12'h004, 8'd17}, // R7 skip
      '{8'd8,  16'h0003, 16'h7080, 16'h0000, 16'h0001, 1'b1, 16'h0000, 12'h003, 8'd14}, // R8 CIR
      '{8'd8,  16'h8001, 16'h7040, 16'h0000, 16'h0002, 1'b1, 16'h0000, 12'h003, 8'd14}, // R8 CIL
      '{8'd8,  16'h00FF, 16'h7200, 16'h0000, 16'hFF00, 1'b0, 16'h0000, 12'h003, 8'd14}, // R8 CMA
      '{8'd8,  16'h7FFF, 16'h7020, 16'h0000, 16'h8000, 1'b0, 16'h0000, 12'h003, 8'd14}, // R8 INC
      '{8'd8,  16'h1234, 16'h7800, 16'h0000, 16'h0000, 1'b0, 16'h0000, 12'h003, 8'd14}, // R8 CLA
      '{8'd8,  16'h0055, 16'h7100, 16'h0000, 16'h0055, 1'b1, 16'h0000, 12'h003, 8'd14}, // R8 CME
      '{8'd9,  16'h0000, 16'h7004, 16'h0000, 16'h0000, 1'b0, 16'h0000, 12'h004, 8'd14}, // R9 zero
      '{8'd9,  16'h8000, 16'h7008, 16'h0000, 16'h8000, 1'b0, 16'h0000, 12'h004, 8'd14}, // R9 neg
      '{8'd9,  16'h8000, 16'h7010, 16'h0000, 16'h8000, 1'b0, 16'h0000, 12'h003, 8'd14}, // R9 pos no
      '{8'd9,  16'h0011, 16'h7002, 16'h0000, 16'h0011, 1'b0, 16'h0000, 12'h004, 8'd14}, // R9 E zero
      '{8'd11, 16'h0077, 16'hF800, 16'h1357, 16'h0077, 1'b0, 16'h1357, 12'h003, 8'd14}  // R11 I/O
   };

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic load_prog(input logic [15:0] a, input logic [15:0] ins, input logic [15:0] b);
      for (int i = 0; i < 256; i++) mem[i] = 16'h7001;
      mem[8'h00] = 16'h2010;
      mem[8'h01] = ins;
      mem[8'h10] = a;
      mem[8'h20] = b;
      mem[8'h30] = 16'h0020;
   endtask

   task automatic run_to_halt(output int cyc);
      cyc = 0;
      @(negedge clk);
      rst_n = 1'b1;
      while (!halted && cyc < 300) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      int cyc;
      string tag;
      logic [11:0] pc_hold;

      // R1: reset state
      load_prog(16'h0001, 16'h7001, 16'h0000);
      repeat (3) @(negedge clk);
      chk("R1", "phase", 32'(phase), 0);
      chk("R1", "pc", 32'(pc_q), 0);
      chk("R1", "ac", 32'(ac_q), 0);
      chk("R1", "e", 32'(e_q), 0);
      chk("R1", "halted", 32'(halted), 0);

      // R2: fetch timing, sampled at falling edges after each rising edge
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R2", "phase after 1 edge", 32'(phase), 1);
      chk("R2", "address in phase 1", 32'(mem_addr), 0);
      chk("R2", "pc in phase 1", 32'(pc_q), 0);
      @(posedge clk); @(negedge clk);
      chk("R2", "phase after 2 edges", 32'(phase), 2);
      chk("R2", "pc after fetch", 32'(pc_q), 1);
      @(posedge clk); @(negedge clk);
      chk("R2", "address after decode", 32'(mem_addr), 32'h010);
      @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R2", "phase cleared after LDA", 32'(phase), 0);
      chk("R4", "ac after LDA", 32'(ac_q), 1);

      // R1: reset in the middle of an instruction
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "phase mid-run reset", 32'(phase), 0);
      chk("R1", "pc mid-run reset", 32'(pc_q), 0);
      chk("R1", "ac mid-run reset", 32'(ac_q), 0);

      // Table-driven programs
      foreach (VECS[k]) begin
         @(negedge clk);
         rst_n = 1'b0;
         load_prog(VECS[k].a_val, VECS[k].instr, VECS[k].b_val);
         tag = $sformatf("R%0d vec%0d", VECS[k].req, k);
         run_to_halt(cyc);
         chk(tag, "cycles to halt", 32'(cyc), 32'(VECS[k].exp_cyc));
         chk(tag, "ac", 32'(ac_q), 32'(VECS[k].exp_ac));
         chk(tag, "e", 32'(e_q), 32'(VECS[k].exp_e));
         chk(tag, "mem[0x20]", 32'(mem[8'h20]), 32'(VECS[k].exp_m20));
         chk(tag, "pc", 32'(pc_q), 32'(VECS[k].exp_pc));
      end

      // R10: halted core stays frozen
      pc_hold = pc_q;
      repeat (12) @(negedge clk);
      chk("R10", "halted held", 32'(halted), 1);
      chk("R10", "phase frozen", 32'(phase), 0);
      chk("R10", "pc frozen", 32'(pc_q), 32'(pc_hold));

      // R10: halt at address 0 costs exactly 4 cycles, then reset restarts
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) mem[i] = 16'h7001;
      run_to_halt(cyc);
      chk("R10", "halt-only cycles", 32'(cyc), 4);
      chk("R10", "pc after halt-only", 32'(pc_q), 1);

      finish_run();
   end

endmodule